// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges six internal reset requests into one internal reset line and holds that line for a fixed number of oscillator cycles. The six requests are power-on, watchdog expiry, low supply voltage, bad opcode, bad address and forced entry into monitor mode. Power-on and low-voltage requests get a long hold followed by a common final phase. All other requests get only the final phase. When the final phase ends, a one-cycle strobe tells the fetch logic it may start reading the reset vector.

The block keeps a status word with one bit per source. Each new reset overwrites it with the bit of the source that caused that reset. A read strobe clears the word. The watchdog request is asynchronous, so it passes through a two-stage synchronizer. The vector address output selects the normal or the monitor-mode vector location.

Top module: `rst_seq_top`

## Requirements
- R1: A one-cycle pulse on any of the five synchronous request inputs drives `rst_int` high from the first clock edge that samples it.
- R2: After a request from watchdog, bad opcode, bad address or monitor entry, `rst_int` stays high for exactly SHORT_CYC (64) cycles.
- R3: After a power-on or low-voltage request, `rst_int` stays high for exactly LONG_CYC + SHORT_CYC (4096 + 64) cycles.
- R4: After a reset, `stat` is one-hot with the bit of the cause set and every other bit clear. The bit positions are: 0 power-on, 1 watchdog, 2 low voltage, 3 bad opcode, 4 bad address, 5 monitor entry.
- R5: If several requests arrive in the same cycle, the lowest bit position is recorded, so power-on always wins. The long hold applies if any of those requests is a long source.
- R6: `seq_done` is high for exactly one cycle: the first cycle in which `rst_int` is low again.
- R7: The watchdog request passes through a two-flop synchronizer. `rst_int` therefore rises two cycles later than it does for the other sources.
- R8: A request that arrives while a sequence is running restarts the count from zero. `rst_int` then stays high for the full length that the new request calls for.
- R9: `vec_addr` is 0xFFFE when `mon_mode` is 0 and 0xFEFE when `mon_mode` is 1, registered one cycle after `mon_mode`.
- R10: A `stat_rd` pulse clears `stat` on the next edge. A request in the same cycle wins, and `stat` then holds the new cause.
- R11: Under `rst`, the block comes up with `rst_int` = 0, `seq_done` = 0, `stat` = 0 and `vec_addr` = 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high initialization of the sequencer flops |
| req_por | input | 1 | Power-on request |
| req_wdog_async | input | 1 | Watchdog expiry request, asynchronous |
| req_lvd | input | 1 | Low-voltage request |
| req_badop | input | 1 | Bad-opcode request |
| req_badaddr | input | 1 | Bad-address request |
| req_mon | input | 1 | Forced monitor-entry request |
| mon_mode | input | 1 | Selects the monitor vector location |
| stat_rd | input | 1 | Status read strobe, clears the status word |
| rst_int | output | 1 | Combined, stretched internal reset |
| seq_done | output | 1 | One-cycle end-of-sequence strobe |
| vec_addr | output | 16 | Address of the reset vector high byte |
| stat | output | 6 | Cause status word |

## Verification
The assertions assume that the synchronous request inputs are single-cycle pulses or levels that change only between clock edges. They also assume that the watchdog input stays high long enough for the first synchronizer stage to catch it. They assume that `rst` is applied at start-up before any request. The stimulus changes every input on the falling edge and pulses each request for exactly one full clock period, including the watchdog request. This keeps the synchronizer free of metastability in simulation and makes the rise latency exactly two cycles.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int NSRC = 6;
  typedef enum logic [2:0] {
    SRC_POR  = 3'd0,
    SRC_WDOG = 3'd1,
    SRC_LVD  = 3'd2,
    SRC_OP   = 3'd3,
    SRC_ADDR = 3'd4,
    SRC_MON  = 3'd5
  } src_e;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LONG  = 2'd1,
    ST_SHORT = 2'd2
  } phase_e;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];

  // R7: the synchronized output can only rise once the first stage has already captured the input
  a_r7_sync_order: assert property (@(posedge clk) disable iff (rst)
    $rose(q_sync) |-> $past(chain[0]));
endmodule

// File: rtl/rst_cause.sv
module rst_cause #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic            rd,
  output logic [NSRC-1:0] stat
);
  logic [NSRC-1:0] first_hit;

  // isolate the lowest asserted request bit (lowest index = highest priority)
  assign first_hit = req & (~req + NSRC'(1));

  always_ff @(posedge clk) begin
    if (rst)       stat <= '0;
    else if (|req) stat <= first_hit;
    else if (rd)   stat <= '0;
  end

  a_r4_onehot_cause: assert property (@(posedge clk) disable iff (rst)
    (|req) |=> $onehot(stat));
  a_r5_por_wins: assert property (@(posedge clk) disable iff (rst)
    req[0] |=> (stat == NSRC'(1)));
  a_r10_read_clear: assert property (@(posedge clk) disable iff (rst)
    (rd && !(|req)) |=> (stat == '0));
endmodule

// File: rtl/rst_timer.sv
module rst_timer
  import rst_seq_pkg::*;
#(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic any_req,
  input  logic long_req,
  output logic rst_out,
  output logic done
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC);

  phase_e        phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= ST_IDLE;
      cnt     <= '0;
      rst_out <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (any_req) begin
        cnt     <= '0;
        phase   <= long_req ? ST_LONG : ST_SHORT;
        rst_out <= 1'b1;
      end else begin
        case (phase)
          ST_LONG: begin
            if (cnt == CW'(LONG_CYC - 1)) begin
              cnt   <= '0;
              phase <= ST_SHORT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_SHORT: begin
            if (cnt == CW'(SHORT_CYC - 1)) begin
              cnt     <= '0;
              phase   <= ST_IDLE;
              rst_out <= 1'b0;
              done    <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    any_req |=> (cnt == '0) && rst_out);
  a_r6_done_at_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out) |-> done);
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_long_to_short: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_LONG && cnt == CW'(LONG_CYC - 1) && !any_req) |=> (phase == ST_SHORT) && rst_out);
  a_r2_hold_in_short: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_SHORT && cnt != CW'(SHORT_CYC - 1)) |=> rst_out);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int          LONG_CYC = 4096,
  parameter int          SHORT_CYC = 64,
  parameter logic [15:0] VEC_NORM = 16'hFFFE,
  parameter logic [15:0] VEC_MON  = 16'hFEFE
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_por,
  input  logic        req_wdog_async,
  input  logic        req_lvd,
  input  logic        req_badop,
  input  logic        req_badaddr,
  input  logic        req_mon,
  input  logic        mon_mode,
  input  logic        stat_rd,
  output logic        rst_int,
  output logic        seq_done,
  output logic [15:0] vec_addr,
  output logic [5:0]  stat
);
  logic            wdog_s;
  logic [NSRC-1:0] req;
  logic            any_req;
  logic            long_req;

  rst_sync2 #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_async(req_wdog_async), .q_sync(wdog_s)
  );

  always_comb begin
    req           = '0;
    req[SRC_POR]  = req_por;
    req[SRC_WDOG] = wdog_s;
    req[SRC_LVD]  = req_lvd;
    req[SRC_OP]   = req_badop;
    req[SRC_ADDR] = req_badaddr;
    req[SRC_MON]  = req_mon;
  end

  assign any_req  = |req;
  assign long_req = req[SRC_POR] | req[SRC_LVD];

  rst_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk(clk), .rst(rst), .any_req(any_req), .long_req(long_req),
    .rst_out(rst_int), .done(seq_done)
  );

  rst_cause #(.NSRC(NSRC)) u_cause (
    .clk(clk), .rst(rst), .req(req), .rd(stat_rd), .stat(stat)
  );

  always_ff @(posedge clk) begin
    if (rst) vec_addr <= VEC_NORM;
    else     vec_addr <= mon_mode ? VEC_MON : VEC_NORM;
  end

  a_r9_vector_sel: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (vec_addr == ($past(mon_mode) ? VEC_MON : VEC_NORM)));
  a_r1_req_asserts: assert property (@(posedge clk) disable iff (rst)
    any_req |=> rst_int);
endmodule

// File: tb/rst_seq_top_tb.sv
module rst_seq_top_tb;
  localparam int LONG_CYC  = 4096;
  localparam int SHORT_CYC = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_por = 0, req_wdog_async = 0, req_lvd = 0, req_badop = 0;
  logic req_badaddr = 0, req_mon = 0, mon_mode = 0, stat_rd = 0;
  logic        rst_int, seq_done;
  logic [15:0] vec_addr;
  logic [5:0]  stat;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rst_seq_top #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_dut (
    .clk(clk), .rst(rst), .req_por(req_por), .req_wdog_async(req_wdog_async),
    .req_lvd(req_lvd), .req_badop(req_badop), .req_badaddr(req_badaddr),
    .req_mon(req_mon), .mon_mode(mon_mode), .stat_rd(stat_rd),
    .rst_int(rst_int), .seq_done(seq_done), .vec_addr(vec_addr), .stat(stat)
  );

  // table: source bit mask, monitor mode, expected stretch, expected rise latency
  localparam int NV = 6;
  localparam logic [5:0] T_MASK [NV] = '{6'h01, 6'h02, 6'h04, 6'h08, 6'h10, 6'h20};
  localparam logic       T_MON  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int         T_LEN  [NV] = '{LONG_CYC + SHORT_CYC, SHORT_CYC, LONG_CYC + SHORT_CYC,
                                         SHORT_CYC, SHORT_CYC, SHORT_CYC};
  localparam int         T_LAT  [NV] = '{1, 3, 1, 1, 1, 1};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_mask(input logic [5:0] m);
    req_por        = m[0];
    req_wdog_async = m[1];
    req_lvd        = m[2];
    req_badop      = m[3];
    req_badaddr    = m[4];
    req_mon        = m[5];
  endtask

  // pulse at a falling edge, then measure latency, high length and done strobe
  task automatic pulse_measure(input logic [5:0] m, output int lat, output int len,
                               output int done_ok);
    drive_mask(m);
    @(negedge clk);
    drive_mask(6'h00);
    lat = 1;
    while (!rst_int && lat < 6) begin
      @(negedge clk);
      lat++;
    end
    len = 0;
    while (rst_int && len < 10000) begin
      len++;
      if (seq_done) done_ok = 0;
      @(negedge clk);
    end
    done_ok = seq_done ? 1 : 0;
    @(negedge clk);
    if (seq_done) done_ok = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int lat, len, dok;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rst_int", rst_int, 0);
    check("R11 seq_done", seq_done, 0);
    check("R11 stat", stat, 0);
    check("R11 vec_addr", vec_addr, 16'hFFFE);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      mon_mode = T_MON[i];
      dok = 1;
      pulse_measure(T_MASK[i], lat, len, dok);
      check("R1/R7 rise latency", lat, T_LAT[i]);
      check((T_LEN[i] > SHORT_CYC) ? "R3 long stretch" : "R2 short stretch", len, T_LEN[i]);
      check("R6 done strobe", dok, 1);
      check("R4 cause bit", stat, T_MASK[i]);
      check("R9 vector", vec_addr, T_MON[i] ? 16'hFEFE : 16'hFFFE);
    end

    // R10 read clear
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R10 read clears", stat, 0);
    check("R10 read leaves reset low", rst_int, 0);

    // R5 simultaneous power-on and bad opcode: power-on recorded, long hold
    mon_mode = 1'b0;
    pulse_measure(6'h09, lat, len, dok);
    check("R5 priority cause", stat, 6'h01);
    check("R5 long applies", len, LONG_CYC + SHORT_CYC);
    // R5 bad address with monitor entry: lower position recorded, short hold
    pulse_measure(6'h30, lat, len, dok);
    check("R5 priority short", stat, 6'h10);
    check("R5 short applies", len, SHORT_CYC);

    // R8 restart mid-sequence
    drive_mask(6'h08);
    @(negedge clk);
    drive_mask(6'h00);
    repeat (30) @(negedge clk);
    check("R8 mid-sequence high", rst_int, 1);
    dok = 1;
    pulse_measure(6'h20, lat, len, dok);
    check("R8 restart length", len, SHORT_CYC);
    check("R8 cause updated", stat, 6'h20);
    // R8 short sequence restarted by long source
    drive_mask(6'h10);
    @(negedge clk);
    drive_mask(6'h00);
    repeat (10) @(negedge clk);
    pulse_measure(6'h04, lat, len, dok);
    check("R8 restart to long", len, LONG_CYC + SHORT_CYC);

    // R10 read and request together: request wins
    stat_rd = 1'b1;
    drive_mask(6'h08);
    @(negedge clk);
    stat_rd = 1'b0;
    drive_mask(6'h00);
    check("R10 request beats read", stat, 6'h08);
    repeat (SHORT_CYC + 2) @(negedge clk);
    check("R2 sequence over", rst_int, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule